// File: doc/BRIEF.md
# Paired-Timer Pulse Channel Engine

This block turns one cycle-start pulse into a set of timed output pulses. A single elapsed-tick counter is shared by eight compare timers. The timers are grouped two per channel, giving four channels. In each channel, the first timer marks the rising edge at a programmed delay. The second timer marks the falling edge at delay plus width. Both are counted in whole clock ticks from the same start.

Each channel has an enable. A switched-off channel keeps its output low, and the completion decision ignores it. Once every enabled channel has finished its pulse, the engine raises a one-cycle end-of-delay strobe. The trigger logic upstream uses this strobe to re-arm.

Delay, width and enable settings are sampled at the accepted start. They can be changed freely while a cycle runs. A start that arrives while a cycle is busy is dropped.

Top module: `pulse_engine`

## Requirements
- R1: After reset, every pulse output and the end-of-delay strobe are low, and all pulse outputs stay low whenever no cycle is running.
- R2: A start sampled at clock edge k while idle begins a cycle. Channel i output goes high after edge k+1+delay_i.
- R3: An enabled channel output stays high for exactly width_i cycles. It goes low after edge k+1+end_i, where end_i is delay_i plus width_i, and it never falls before it has risen.
- R4: The end count saturates at 2^CNT_W-1 when delay plus width overflows. The output then falls after edge k+1+(2^CNT_W-1).
- R5: A channel whose width is zero never drives its output high.
- R6: The end-of-delay strobe is high for exactly one cycle, after edge k+2+E, where E is the largest end count among enabled channels.
- R7: A disabled channel keeps its output low, and its delay and width have no effect on when end-of-delay occurs.
- R8: With all channels disabled, end-of-delay is high after edge k+1.
- R9: A start sampled between edge k and the edge that issues end-of-delay, inclusive, is ignored. A start sampled in the cycle where end-of-delay is high is accepted as a new cycle.
- R10: Delay, width and enable inputs are captured at the accepted start edge. Changes to them during a running cycle do not alter that cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all timing counts its rising edges |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Cycle-start request, sampled each edge |
| chan_en_i | input | NCH | Per-channel enable, bit i for channel i |
| delay_i | input | NCH*CNT_W | Rising-edge delay in ticks, channel i in bits [i*CNT_W +: CNT_W] |
| width_i | input | NCH*CNT_W | Pulse width in ticks, same packing as delay_i |
| pulse_o | output | NCH | Channel pulse outputs |
| eod_o | output | 1 | One-cycle end-of-delay strobe |

## Verification
Every result is tied to the start edge k. Channel i output is high from edge k+1+delay_i until edge k+1+end_i. End-of-delay is high from edge k+2+E, or from edge k+1 when no channel is enabled.

The driver turns each case into one expected item per cycle, numbered from edge k. The monitor pops one item one nanosecond after every rising edge, so each sample falls exactly in the cycle the count predicts.

Chained cases put the next start on the end-of-delay cycle. Their item streams then abut without a gap, which checks the re-arm edge cycle for cycle.

// File: rtl/pe_pkg.sv
package pe_pkg;
  typedef enum logic {
    RUN_IDLE = 1'b0,
    RUN_BUSY = 1'b1
  } run_state_e;

  localparam int TIMERS_PER_CHAN = 2;
endpackage

// File: rtl/pe_tick_counter.sv
module pe_tick_counter #(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clear_i,
  input  logic             run_i,
  output logic [CNT_W-1:0] cnt_o
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_o <= '0;
    end else if (clear_i) begin
      cnt_o <= '0;
    end else if (run_i && (cnt_o != CNT_MAX)) begin
      cnt_o <= cnt_o + 1'b1;
    end
  end
endmodule

// File: rtl/pe_timer.sv
module pe_timer #(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clear_i,
  input  logic             run_i,
  input  logic [CNT_W-1:0] target_i,
  input  logic [CNT_W-1:0] cnt_i,
  output logic             fired_o
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      fired_o <= 1'b0;
    end else if (clear_i) begin
      fired_o <= 1'b0;
    end else if (run_i && (cnt_i == target_i)) begin
      fired_o <= 1'b1;
    end
  end
endmodule

// File: rtl/pe_channel.sv
module pe_channel #(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load_i,
  input  logic             run_i,
  input  logic             en_i,
  input  logic [CNT_W-1:0] dly_i,
  input  logic [CNT_W-1:0] wid_i,
  input  logic [CNT_W-1:0] cnt_i,
  output logic             pulse_o,
  output logic             done_o
);
  import pe_pkg::*;

  logic [CNT_W:0]   sum_wide;
  logic [CNT_W-1:0] end_sat;
  logic             en_q;
  logic [CNT_W-1:0] dly_q;
  logic [CNT_W-1:0] end_q;
  logic [TIMERS_PER_CHAN-1:0][CNT_W-1:0] tgt;
  logic [TIMERS_PER_CHAN-1:0]            fired;

  always_comb begin
    sum_wide = {1'b0, dly_i} + {1'b0, wid_i};
    end_sat  = sum_wide[CNT_W] ? '1 : sum_wide[CNT_W-1:0];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      en_q  <= 1'b0;
      dly_q <= '0;
      end_q <= '0;
    end else if (load_i) begin
      en_q  <= en_i;
      dly_q <= dly_i;
      end_q <= end_sat;
    end
  end

  assign tgt[0] = dly_q;
  assign tgt[1] = end_q;

  for (genvar t = 0; t < TIMERS_PER_CHAN; t++) begin : g_tmr
    pe_timer #(.CNT_W(CNT_W)) u_tmr (
      .clk      (clk),
      .rst_n    (rst_n),
      .clear_i  (load_i),
      .run_i    (run_i),
      .target_i (tgt[t]),
      .cnt_i    (cnt_i),
      .fired_o  (fired[t])
    );
  end

  assign pulse_o = en_q & fired[0] & ~fired[1];
  assign done_o  = ~en_q | fired[1];

  assert_end_not_below_R4: assert property (@(posedge clk) disable iff (!rst_n)
    end_q >= dly_q);

  assert_fall_needs_rise_R3: assert property (@(posedge clk) disable iff (!rst_n)
    fired[1] |-> fired[0]);
endmodule

// File: rtl/pe_run_ctrl.sv
module pe_run_ctrl (
  input  logic clk,
  input  logic rst_n,
  input  logic start_i,
  input  logic all_done_i,
  output logic load_o,
  output logic run_o,
  output logic eod_o
);
  import pe_pkg::*;

  run_state_e state_q;

  assign load_o = start_i && (state_q == RUN_IDLE);
  assign run_o  = (state_q == RUN_BUSY);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= RUN_IDLE;
      eod_o   <= 1'b0;
    end else begin
      eod_o <= 1'b0;
      unique case (state_q)
        RUN_IDLE: if (start_i) state_q <= RUN_BUSY;
        RUN_BUSY: if (all_done_i) begin
          state_q <= RUN_IDLE;
          eod_o   <= 1'b1;
        end
        default: state_q <= RUN_IDLE;
      endcase
    end
  end

  assert_eod_single_R6: assert property (@(posedge clk) disable iff (!rst_n)
    eod_o |=> !eod_o);
endmodule

// File: rtl/pulse_engine.sv
module pulse_engine #(
  parameter int NCH   = 4,
  parameter int CNT_W = 32
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 start_i,
  input  logic [NCH-1:0]       chan_en_i,
  input  logic [NCH*CNT_W-1:0] delay_i,
  input  logic [NCH*CNT_W-1:0] width_i,
  output logic [NCH-1:0]       pulse_o,
  output logic                 eod_o
);
  logic             load;
  logic             run;
  logic [CNT_W-1:0] cnt;
  logic [NCH-1:0]   done;

  pe_run_ctrl u_ctrl (
    .clk        (clk),
    .rst_n      (rst_n),
    .start_i    (start_i),
    .all_done_i (&done),
    .load_o     (load),
    .run_o      (run),
    .eod_o      (eod_o)
  );

  pe_tick_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk     (clk),
    .rst_n   (rst_n),
    .clear_i (load),
    .run_i   (run),
    .cnt_o   (cnt)
  );

  for (genvar i = 0; i < NCH; i++) begin : g_ch
    pe_channel #(.CNT_W(CNT_W)) u_ch (
      .clk     (clk),
      .rst_n   (rst_n),
      .load_i  (load),
      .run_i   (run),
      .en_i    (chan_en_i[i]),
      .dly_i   (delay_i[i*CNT_W +: CNT_W]),
      .wid_i   (width_i[i*CNT_W +: CNT_W]),
      .cnt_i   (cnt),
      .pulse_o (pulse_o[i]),
      .done_o  (done[i])
    );
  end

  assert_idle_outputs_low_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !run |-> (pulse_o == '0));

  assert_start_ignored_busy_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (run && start_i && (cnt != '0)) |=> (cnt != '0));

  assert_all_off_eod_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (start_i && !run && (chan_en_i == '0)) |=> ##1 eod_o);
endmodule

// File: tb/pulse_engine_tb.sv
module pulse_engine_tb;
  localparam int NCH  = 4;
  localparam int BW   = 10;
  localparam int BMAX = (1 << BW) - 1;

  typedef struct {
    logic [NCH-1:0] p;
    logic           e;
    int             t;
    string          tag;
  } exp_t;

  logic                clk = 1'b0;
  logic                rst_n = 1'b0;
  logic                start = 1'b0;
  logic [NCH-1:0]      drv_en = '0;
  logic [NCH*BW-1:0]   drv_dly = '0;
  logic [NCH*BW-1:0]   drv_wid = '0;
  logic [NCH-1:0]      pulse;
  logic                eod;

  int    checks = 0;
  int    errors = 0;
  bit    finished = 1'b0;
  exp_t  q[$];
  int    cfg_d[NCH];
  int    cfg_w[NCH];
  logic [NCH-1:0] cfg_en;

  always #2 clk = ~clk;

  pulse_engine #(.NCH(NCH), .CNT_W(BW)) u_dut (
    .clk       (clk),
    .rst_n     (rst_n),
    .start_i   (start),
    .chan_en_i (drv_en),
    .delay_i   (drv_dly),
    .width_i   (drv_wid),
    .pulse_o   (pulse),
    .eod_o     (eod)
  );

  // Monitor: one expected item per cycle, sampled 1 ns after the edge
  initial begin
    forever begin
      @(posedge clk);
      #1;
      if (q.size() > 0) begin
        exp_t it;
        it = q.pop_front();
        checks++;
        if (pulse !== it.p || eod !== it.e) begin
          errors++;
          $display("FAIL %s t=%0d pulse=%b eod=%b expected pulse=%b eod=%b",
                   it.tag, it.t, pulse, eod, it.p, it.e);
        end
      end
    end
  end

  task automatic run_case(input string tag, input int extra_at, input bit chain);
    int ends[NCH];
    int maxe;
    int eod_t;
    maxe = -1;
    for (int i = 0; i < NCH; i++) begin
      ends[i] = cfg_d[i] + cfg_w[i];
      if (ends[i] > BMAX) ends[i] = BMAX;
      if (cfg_en[i] && ends[i] > maxe) maxe = ends[i];
    end
    eod_t = (maxe < 0) ? 1 : maxe + 2;
    for (int t = 0; t <= eod_t + (chain ? 0 : 1); t++) begin
      exp_t it;
      for (int i = 0; i < NCH; i++)
        it.p[i] = cfg_en[i] && (t - 1 >= cfg_d[i]) && (t - 1 < ends[i]);
      it.e   = (t == eod_t);
      it.t   = t;
      it.tag = tag;
      q.push_back(it);
    end
    for (int i = 0; i < NCH; i++) begin
      drv_dly[i*BW +: BW] = BW'(cfg_d[i]);
      drv_wid[i*BW +: BW] = BW'(cfg_w[i]);
    end
    drv_en = cfg_en;
    start  = 1'b1;
    @(negedge clk);
    start = 1'b0;
    // R10: scramble settings while the cycle runs
    drv_dly = ~drv_dly;
    drv_wid = drv_wid ^ {NCH{10'h155}};
    drv_en  = ~drv_en;
    for (int j = 1; j <= eod_t; j++) begin
      if (j == extra_at) start = 1'b1;
      @(negedge clk);
      start = 1'b0;
    end
    if (!chain) begin
      wait (q.size() == 0);
      @(negedge clk);
    end
  endtask

  task automatic set_cfg(input int d0, w0, d1, w1, d2, w2, d3, w3,
                         input logic [NCH-1:0] en);
    cfg_d[0] = d0; cfg_w[0] = w0;
    cfg_d[1] = d1; cfg_w[1] = w1;
    cfg_d[2] = d2; cfg_w[2] = w2;
    cfg_d[3] = d3; cfg_w[3] = w3;
    cfg_en   = en;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(posedge clk);
    #1;
    checks++;
    if (pulse !== '0 || eod !== 1'b0) begin
      errors++;
      $display("FAIL R1 reset pulse=%b eod=%b expected pulse=0000 eod=0", pulse, eod);
    end
    @(negedge clk);

    set_cfg(0, 1, 3, 4, 5, 2, 10, 6, 4'b1111);
    run_case("R2 R3 R6 R10 basic", 0, 1'b0);

    set_cfg(2, 3, 4, 0, 1, 7, 6, 1, 4'b1111);
    run_case("R5 zero width", 0, 1'b0);

    set_cfg(900, 100, 3, 5, 950, 60, 2, 2, 4'b1010);
    run_case("R7 disabled channels", 0, 1'b0);

    set_cfg(7, 7, 8, 8, 9, 9, 5, 5, 4'b0000);
    run_case("R8 all off", 0, 1'b0);

    set_cfg(1, 4, 2, 9, 0, 3, 5, 2, 4'b1111);
    run_case("R9 start while busy", 4, 1'b0);

    set_cfg(1, 2, 0, 1, 3, 1, 2, 2, 4'b0111);
    run_case("R9 R6 start at eod first", 0, 1'b1);
    set_cfg(0, 2, 4, 3, 1, 1, 2, 5, 4'b1101);
    run_case("R9 back-to-back second", 0, 1'b0);

    set_cfg(1000, 100, 2, 3, 0, 0, 0, 0, 4'b0011);
    run_case("R4 saturated end", 0, 1'b0);

    if (!finished) begin
      finished = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      checks++;
      errors++;
      $display("FAIL watchdog run did not complete");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule